// File: doc/BRIEF.md
# Cartridge Bank Register Decoder

This block sits on the processor write path of a banked cartridge. Each accepted write in the upper half of the address space is decoded into one of a small set of bank registers. There are two switchable program bank registers, a mirroring register, a control register and eight 9-bit pattern bank registers. The pattern registers are loaded four bits at a time. From these registers the block continuously drives four 8 KB program slot bank numbers, eight 1 KB pattern slot bank numbers and a two-bit nametable mirroring code. Memory storage and the interval counter registers in the top 4 KB of the space live elsewhere.

Writes arrive on a valid/ready channel. `wr_ready_o` is held high, so the block never applies back-pressure and a write is taken on every cycle in which `wr_valid_i` is high. The effect of a write is visible on the outputs from the following clock cycle. The bank outputs are plain registered-state outputs with no handshake.

Top module: `cart_bank_decoder`

## Requirements
- R1: After reset, program slots read 0, 0, 14, 15, pattern slot i reads i for i = 0..7, and the mirroring code is 0.
- R2: `wr_ready_o` is always 1. A write takes effect on the cycle after the one in which `wr_valid_i` is 1. Nothing changes while `wr_valid_i` is 0.
- R3: Before decoding, the address is reduced to its bits 15:12 and 1:0 (mask 0xF003). A write with address bit 15 equal to 0 has no effect.
- R4: A write to the 0x8000 range loads program register 0, and a write to the 0xA000 range loads program register 1. Address bit 13 picks the register. The low four data bits form the bank number.
- R5: Slot 3 (0xE000) always reads 15. Slot 1 (0xA000) reads program register 1.
- R6: When control bit 1 is 0, slot 0 reads program register 0 and slot 2 reads 14. When it is 1, the two are exchanged: slot 0 reads 14 and slot 2 reads program register 0.
- R7: A write to the 0x9000 range with address bit 1 = 0 loads the mirroring code from data bits 1:0. The codes are 0 vertical, 1 horizontal, 2 single-screen lower and 3 single-screen upper.
- R8: A write to the 0x9000 range with address bits 1:0 = 2 loads the control register. With bits 1:0 = 3 the write has no effect.
- R9: A write in the 0xB000–0xE003 ranges selects pattern register ((masked address − 0xB000) >> 11) | address bit 1. So 0xB000→0, 0xB002→1, 0xC000→2, …, 0xE002→7.
- R10: With address bit 0 = 0, the selected pattern register's bits 3:0 take data bits 3:0. Bits 8:4 are kept.
- R11: With address bit 0 = 1, the selected pattern register's bits 8:4 take data bits 4:0. Bits 3:0 are kept.
- R12: Writes to the 0xF000 range change no output of this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write accepted (held high) |
| wr_addr_i | input | 16 | Processor write address |
| wr_data_i | input | 8 | Processor write data |
| prg_bank_o | output | 4x4 | Program bank number per 8 KB slot, index 0 = 0x8000 |
| chr_bank_o | output | 8x9 | Pattern bank number per 1 KB slot |
| mirror_o | output | 2 | Nametable mirroring code |

## Verification
Every register drives an output directly, so a wrong register value shows at the ports one cycle after the write that caused it. A misdecoded index shows as an unexpected change in the neighbouring slot's bank number in that same cycle. A swap or fixed-bank fault shows at once on slots 0 and 2. An ignored-range write that leaks through alters some output on the next cycle, so snapshots taken before and after such writes expose it.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int NUM_CHR  = 8;
  localparam int CHR_IDXW = $clog2(NUM_CHR);
  localparam int NUM_PRG  = 2;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORIZ  = 2'd1,
    MIR_LOWER  = 2'd2,
    MIR_UPPER  = 2'd3
  } mirror_e;

  typedef struct packed {
    logic [NUM_PRG-1:0] prg_we;
    logic               mir_we;
    logic               ctl_we;
    logic [NUM_CHR-1:0] chr_we;
    logic               chr_hi;
  } wr_dec_t;
endpackage

// File: rtl/cbd_addr_decode.sv
module cbd_addr_decode
  import cbd_pkg::*;
(
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_dec_t           dec_o
);
  localparam logic [ADDR_W-1:0] ADDR_MASK = 16'hF003;
  localparam logic [ADDR_W-1:0] CHR_BASE  = 16'hB000;

  logic [ADDR_W-1:0] a_m;
  logic [ADDR_W-1:0] chr_off;
  logic [CHR_IDXW-1:0] chr_idx;
  logic [3:0] page;

  always_comb begin
    a_m     = addr_i & ADDR_MASK;
    page    = a_m[15:12];
    chr_off = a_m - CHR_BASE;
    chr_idx = chr_off[13:11] | {{(CHR_IDXW-1){1'b0}}, a_m[1]};
    dec_o   = '0;
    dec_o.chr_hi = a_m[0];
    if (valid_i) begin
      unique case (page)
        4'h8, 4'hA: dec_o.prg_we[a_m[13]] = 1'b1;
        4'h9: begin
          if (!a_m[1])      dec_o.mir_we = 1'b1;
          else if (!a_m[0]) dec_o.ctl_we = 1'b1;
        end
        4'hB, 4'hC, 4'hD, 4'hE: dec_o.chr_we[chr_idx] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cbd_ctrl_regs.sv
module cbd_ctrl_regs
  import cbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_dec_t           dec_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NUM_PRG-1:0][DATA_W-1:0] prg_reg_o,
  output mirror_e           mirror_o,
  output logic [DATA_W-1:0] ctl_o
);
  for (genvar p = 0; p < NUM_PRG; p++) begin : g_prg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             prg_reg_o[p] <= '0;
      else if (dec_i.prg_we[p]) prg_reg_o[p] <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mirror_o <= MIR_VERT;
      ctl_o    <= '0;
    end else begin
      if (dec_i.mir_we) mirror_o <= mirror_e'(data_i[1:0]);
      if (dec_i.ctl_we) ctl_o    <= data_i;
    end
  end
endmodule

// File: rtl/cbd_chr_regs.sv
module cbd_chr_regs
  import cbd_pkg::*;
#(
  parameter int CHR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_dec_t           dec_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NUM_CHR-1:0][CHR_W-1:0] chr_o
);
  localparam int LO_W = 4;
  localparam int HI_W = CHR_W - LO_W;

  for (genvar i = 0; i < NUM_CHR; i++) begin : g_chr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chr_o[i] <= CHR_W'(i);
      end else if (dec_i.chr_we[i]) begin
        if (dec_i.chr_hi) chr_o[i] <= {data_i[HI_W-1:0], chr_o[i][LO_W-1:0]};
        else              chr_o[i] <= {chr_o[i][CHR_W-1:LO_W], data_i[LO_W-1:0]};
      end
    end
  end
endmodule

// File: rtl/cbd_prg_map.sv
module cbd_prg_map
  import cbd_pkg::*;
#(
  parameter int PRG_OUT_W = 4
) (
  input  logic [NUM_PRG-1:0][DATA_W-1:0] prg_reg_i,
  input  logic                           swap_i,
  output logic [3:0][PRG_OUT_W-1:0]      slot_o
);
  localparam logic [PRG_OUT_W-1:0] BANK_LAST = '1;
  localparam logic [PRG_OUT_W-1:0] BANK_PENULT = BANK_LAST - 1'b1;

  logic [PRG_OUT_W-1:0] sel0;

  always_comb begin
    sel0      = prg_reg_i[0][PRG_OUT_W-1:0];
    slot_o[0] = swap_i ? BANK_PENULT : sel0;
    slot_o[1] = prg_reg_i[1][PRG_OUT_W-1:0];
    slot_o[2] = swap_i ? sel0 : BANK_PENULT;
    slot_o[3] = BANK_LAST;
  end
endmodule

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder
  import cbd_pkg::*;
#(
  parameter int CHR_W     = 9,
  parameter int PRG_OUT_W = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_valid_i,
  output logic                             wr_ready_o,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  output logic [3:0][PRG_OUT_W-1:0]        prg_bank_o,
  output logic [NUM_CHR-1:0][CHR_W-1:0]    chr_bank_o,
  output logic [1:0]                       mirror_o
);
  localparam int SWAP_BIT = 1;

  wr_dec_t dec;
  logic [NUM_PRG-1:0][DATA_W-1:0] prg_reg;
  mirror_e mir_q;
  logic [DATA_W-1:0] ctl_q;

  assign wr_ready_o = 1'b1;

  cbd_addr_decode u_dec (
    .valid_i (wr_valid_i & wr_ready_o),
    .addr_i  (wr_addr_i),
    .dec_o   (dec)
  );

  cbd_ctrl_regs u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_i     (dec),
    .data_i    (wr_data_i),
    .prg_reg_o (prg_reg),
    .mirror_o  (mir_q),
    .ctl_o     (ctl_q)
  );

  cbd_chr_regs #(.CHR_W(CHR_W)) u_chr (
    .clk    (clk),
    .rst_n  (rst_n),
    .dec_i  (dec),
    .data_i (wr_data_i),
    .chr_o  (chr_bank_o)
  );

  cbd_prg_map #(.PRG_OUT_W(PRG_OUT_W)) u_prg (
    .prg_reg_i (prg_reg),
    .swap_i    (ctl_q[SWAP_BIT]),
    .slot_o    (prg_bank_o)
  );

  assign mirror_o = mir_q;
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker
  import cbd_pkg::*;
#(
  parameter int CHR_W     = 9,
  parameter int PRG_OUT_W = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_valid_i,
  input logic                          wr_ready_o,
  input logic [ADDR_W-1:0]             wr_addr_i,
  input logic [DATA_W-1:0]             wr_data_i,
  input logic [3:0][PRG_OUT_W-1:0]     prg_bank_o,
  input logic [NUM_CHR-1:0][CHR_W-1:0] chr_bank_o,
  input logic [1:0]                    mirror_o
);
  localparam logic [PRG_OUT_W-1:0] PENULT = {{(PRG_OUT_W-1){1'b1}}, 1'b0};

  logic [ADDR_W-1:0] am;
  assign am = wr_addr_i & 16'hF003;

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid_i |=> ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_o)));

  assert_ready_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready_o);

  assert_upper_range_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && am[15:12] == 4'hF) |=>
      ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_o)));

  assert_low_half_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !wr_addr_i[15]) |=>
      ($stable(prg_bank_o) && $stable(chr_bank_o) && $stable(mirror_o)));

  assert_mirror_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mirror_o != $past(mirror_o)) |->
      $past(wr_valid_i && am[15:12] == 4'h9 && !am[1]));

  assert_prg0_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && am[15:12] == 4'h8) |=>
      (prg_bank_o[0] == $past(wr_data_i[PRG_OUT_W-1:0]) ||
       prg_bank_o[2] == $past(wr_data_i[PRG_OUT_W-1:0])));

  assert_swap_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prg_bank_o[0] == PENULT) || (prg_bank_o[2] == PENULT));

  assert_chr0_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && am == 16'hB000) |=>
      (chr_bank_o[0][3:0] == $past(wr_data_i[3:0]) &&
       chr_bank_o[0][CHR_W-1:4] == $past(chr_bank_o[0][CHR_W-1:4])));

  assert_chr0_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && am == 16'hB001) |=>
      (chr_bank_o[0][CHR_W-1:4] == $past(wr_data_i[CHR_W-5:0]) &&
       chr_bank_o[0][3:0] == $past(chr_bank_o[0][3:0])));
endmodule

bind cart_bank_decoder cbd_checker #(.CHR_W(CHR_W), .PRG_OUT_W(PRG_OUT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid_i (wr_valid_i),
  .wr_ready_o (wr_ready_o),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .prg_bank_o (prg_bank_o),
  .chr_bank_o (chr_bank_o),
  .mirror_o   (mirror_o)
);

// File: tb/cart_bank_decoder_tb_top.sv
module cart_bank_decoder_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic wr_valid = 0;
  logic wr_ready;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0][3:0] prg;
  logic [7:0][8:0] chr;
  logic [1:0] mir;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cart_bank_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .prg_bank_o(prg), .chr_bank_o(chr), .mirror_o(mir)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  logic [3:0][3:0] s_prg;
  logic [7:0][8:0] s_chr;
  logic [1:0] s_mir;

  task automatic snap();
    s_prg = prg; s_chr = chr; s_mir = mir;
  endtask

  task automatic same(input string req, input string what);
    chk(req, {what, " prg"}, 16'(prg), 16'(s_prg));
    for (int i = 0; i < 8; i++) chk(req, {what, " chr"}, 16'(chr[i]), 16'(s_chr[i]));
    chk(req, {what, " mir"}, 16'(mir), 16'(s_mir));
  endtask

  task automatic t_reset();
    chk("R1", "slot0", 16'(prg[0]), 16'h0);
    chk("R1", "slot1", 16'(prg[1]), 16'h0);
    chk("R1", "slot2", 16'(prg[2]), 16'hE);
    chk("R1", "slot3", 16'(prg[3]), 16'hF);
    for (int i = 0; i < 8; i++) chk("R1", "chr", 16'(chr[i]), 16'(i));
    chk("R1", "mirror", 16'(mir), 16'h0);
    chk("R2", "ready", 16'(wr_ready), 16'h1);
  endtask

  task automatic t_prg();
    wr(16'h8000, 8'h35);
    chk("R4", "prg0 low bits", 16'(prg[0]), 16'h5);
    wr(16'hA7F2, 8'h1C);
    chk("R4", "prg1 via masked addr", 16'(prg[1]), 16'hC);
    chk("R5", "slot2 fixed", 16'(prg[2]), 16'hE);
    chk("R5", "slot3 fixed", 16'(prg[3]), 16'hF);
  endtask

  task automatic t_swap();
    wr(16'h9002, 8'h02);
    chk("R6", "swapped slot0", 16'(prg[0]), 16'hE);
    chk("R6", "swapped slot2", 16'(prg[2]), 16'h5);
    chk("R5", "slot3 under swap", 16'(prg[3]), 16'hF);
    wr(16'h9002, 8'h00);
    chk("R6", "unswapped slot0", 16'(prg[0]), 16'h5);
    snap();
    wr(16'h9003, 8'h02);
    same("R8", "bits 1:0 = 3 no effect");
  endtask

  task automatic t_mirror();
    for (int m = 0; m < 4; m++) begin
      wr(16'h9000, 8'hF0 | 8'(m));
      chk("R7", "mirror code", 16'(mir), 16'(m));
    end
    wr(16'h9001, 8'h01);
    chk("R7", "mirror A0 don't care", 16'(mir), 16'h1);
    chk("R8", "mirror write leaves swap off", 16'(prg[0]), 16'h5);
  endtask

  task automatic t_chr();
    for (int i = 0; i < 8; i++) begin
      logic [15:0] a;
      logic [7:0] lo, hi;
      a  = 16'hB000 + 16'((i >> 1) * 16'h1000) + 16'((i & 1) * 2);
      lo = 8'hF0 | 8'((i + 5) & 15);
      hi = 8'hE0 | 8'((i * 3 + 1) & 31);
      wr(a, lo);
      chk("R10", "chr low nibble", 16'(chr[i]), 16'({5'd0, lo[3:0]}));
      wr(a | 16'h1, hi);
      chk("R11", "chr high bits", 16'(chr[i]), 16'({hi[4:0], lo[3:0]}));
      wr(a, 8'h03);
      chk("R10", "high kept", 16'(chr[i]), 16'({hi[4:0], 4'h3}));
      if (i > 0) chk("R9", "neighbour untouched", 16'(chr[i-1]), 16'({5'(((i-1)*3+1) & 31), 4'h3}));
    end
  endtask

  task automatic t_ignored();
    snap();
    for (int k = 0; k < 4; k++) wr(16'hF000 | 16'(k), 8'hFF);
    same("R12", "upper range");
    wr(16'h3000, 8'hFF);
    wr(16'h0000, 8'hFF);
    wr(16'h1002, 8'hFF);
    same("R3", "low half");
    @(negedge clk);
    wr_addr = 16'h8000; wr_data = 8'hAA;
    @(negedge clk);
    @(negedge clk);
    same("R2", "no valid");
  endtask

  task automatic t_alias();
    wr(16'hB0FC, 8'h09);
    chk("R3", "masked alias to chr0 low", 16'(chr[0][3:0]), 16'h9);
    wr(16'hE3FE, 8'h0A);
    chk("R9", "0xE002 alias index 7", 16'(chr[7][3:0]), 16'hA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_prg();
    t_swap();
    t_mirror();
    t_chr();
    t_ignored();
    t_alias();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule